// File: doc/BRIEF.md
# Port-Mapped Peripheral Fabric

This block sits beside a small 8-bit controller core that reaches its peripherals through port-addressed input and output instructions. The core presents an 8-bit port address, and it pulses a write strobe to store a byte or a read strobe to fetch one. The fabric decodes each address to one of five targets: a 64-byte scratch RAM, a 64-byte constant table, a bidirectional register, an output-only register and a sampled input register. The result of a read is registered and is returned on the cycle after the strobe, which matches a two-cycle input instruction.

The fabric also holds the core's interrupt request. This is a two-state machine with the states `IRQ_IDLE` and `IRQ_PEND`. The transition `IDLE->PEND` is taken when the external event line is high. The transition `PEND->IDLE` is taken when the core's acknowledge pulse arrives and no new event arrives in the same cycle. In every other case the state is kept, so an event is never lost. The request output is high exactly in `IRQ_PEND`.

A synchronous reset clears every storage element, including the RAM and the interrupt state.

Top module: `pio_fabric`

## Requirements
- R1: Ports 0x00 to 0x3F select a 64-byte RAM. A write strobe stores `wr_data` at that location, and a later read of the same port returns the stored byte.
- R2: Read data is registered. `rd_data` takes the addressed value on the clock edge that samples `rd_strobe`, and it holds that value while `rd_strobe` is low.
- R3: Ports 0x40 to 0x7F read a constant table. Entry i, where i is the low 6 address bits, is `((i*37+5) mod 256) XOR 0xA5`. Writes to this range change no state.
- R4: Port 0x80 is one register that can be both written and read. A read returns the last byte written, and `io_a_out` shows the register's value continuously.
- R5: Port 0xC0 is a write-only register shown on `io_b_out`. Reading port 0xC0 returns 0x00.
- R6: Port 0xCF is an input register that samples `ext_in` on every clock. A read returns the sampled byte. Writes to 0xCF have no effect.
- R7: Reads of unmapped ports (0x81 to 0xBF, 0xC1 to 0xCE, 0xD0 to 0xFF) return 0x00. Writes to these ports change no RAM byte and no output register.
- R8: A high `ext_event` sampled at a clock edge makes `irq` high from that edge onwards.
- R9: A high `irq_ack` clears `irq` at the next edge. If `ext_event` is high in the same cycle, the event wins and `irq` stays high.
- R10: A synchronous `rst` clears `rd_data`, `irq`, both output registers and all RAM bytes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_addr | input | 8 | Port address from the core |
| wr_data | input | 8 | Byte to store on a write |
| wr_strobe | input | 1 | Write strobe, one cycle |
| rd_strobe | input | 1 | Read strobe, one cycle |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| ext_event | input | 1 | External event that raises the request |
| ext_in | input | 8 | External input bus, sampled at 0xCF |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request to the core |
| io_a_out | output | 8 | Contents of the register at 0x80 |
| io_b_out | output | 8 | Contents of the register at 0xC0 |

## Verification
Most faults in this block appear at the ports within two clocks: one clock for the access itself and one for the registered read. A decode fault that sends a write to the wrong target shows up later, when the wrong RAM byte or output register is read back. This is why every write in the bench is followed by reads of the intended target and of the neighbouring targets. A wrong interrupt state is visible on `irq` on the very next cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_ROM,
        RGN_IOA,
        RGN_IOB,
        RGN_INB
    } pio_region_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_state_e;

    function automatic logic [DW-1:0] table_value(input logic [AW-1:0] idx);
        logic [15:0] t;
        t = 16'(idx) * 16'd37 + 16'd5;
        return t[DW-1:0] ^ 8'hA5;
    endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int          MEM_DEPTH = 64,
    parameter logic [7:0]  IOA_ADDR  = 8'h80,
    parameter logic [7:0]  IOB_ADDR  = 8'hC0,
    parameter logic [7:0]  INB_ADDR  = 8'hCF
) (
    input  logic [AW-1:0] addr,
    output pio_region_e   region
);
    localparam int RAM_END = MEM_DEPTH;
    localparam int ROM_END = 2 * MEM_DEPTH;

    always_comb begin
        if (int'(addr) < RAM_END)      region = RGN_RAM;
        else if (int'(addr) < ROM_END) region = RGN_ROM;
        else if (addr == IOA_ADDR)     region = RGN_IOA;
        else if (addr == IOB_ADDR)     region = RGN_IOB;
        else if (addr == INB_ADDR)     region = RGN_INB;
        else                           region = RGN_NONE;
    end
endmodule

// File: rtl/pio_ram.sv
module pio_ram
    import pio_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/pio_irq_fsm.sv
module pio_irq_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic event_in,
    input  logic ack,
    output logic req
);
    irq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE: if (event_in)         state_nx = IRQ_PEND;
            IRQ_PEND: if (ack && !event_in) state_nx = IRQ_IDLE;
            default:                        state_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IRQ_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            IRQ_PEND: req = 1'b1;
            default:  req = 1'b0;
        endcase
    end
endmodule

// File: rtl/pio_fabric.sv
module pio_fabric
    import pio_pkg::*;
#(
    parameter int         MEM_DEPTH = 64,
    parameter logic [7:0] IOA_ADDR  = 8'h80,
    parameter logic [7:0] IOB_ADDR  = 8'hC0,
    parameter logic [7:0] INB_ADDR  = 8'hCF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] port_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_strobe,
    input  logic          rd_strobe,
    input  logic          irq_ack,
    input  logic          ext_event,
    input  logic [DW-1:0] ext_in,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic [DW-1:0] io_a_out,
    output logic [DW-1:0] io_b_out
);
    localparam int IW = $clog2(MEM_DEPTH);

    pio_region_e   region;
    logic [DW-1:0] ram_q;
    logic [DW-1:0] rom_q;
    logic [DW-1:0] ioa_q, iob_q, inb_q;
    logic [DW-1:0] rd_mux;

    pio_decode #(
        .MEM_DEPTH (MEM_DEPTH),
        .IOA_ADDR  (IOA_ADDR),
        .IOB_ADDR  (IOB_ADDR),
        .INB_ADDR  (INB_ADDR)
    ) u_decode (
        .addr   (port_addr),
        .region (region)
    );

    pio_ram #(.DEPTH(MEM_DEPTH)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_strobe && region == RGN_RAM),
        .idx   (port_addr[IW-1:0]),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    assign rom_q = table_value(AW'(port_addr[IW-1:0]));

    pio_irq_fsm u_irq (
        .clk      (clk),
        .rst      (rst),
        .event_in (ext_event),
        .ack      (irq_ack),
        .req      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ioa_q <= '0;
            iob_q <= '0;
            inb_q <= '0;
        end else begin
            inb_q <= ext_in;
            if (wr_strobe && region == RGN_IOA) ioa_q <= wr_data;
            if (wr_strobe && region == RGN_IOB) iob_q <= wr_data;
        end
    end

    always_comb begin
        unique case (region)
            RGN_RAM: rd_mux = ram_q;
            RGN_ROM: rd_mux = rom_q;
            RGN_IOA: rd_mux = ioa_q;
            RGN_INB: rd_mux = inb_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_mux;
    end

    assign io_a_out = ioa_q;
    assign io_b_out = iob_q;
endmodule

// File: rtl/pio_fabric_chk.sv
module pio_fabric_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] port_addr,
    input logic [7:0] wr_data,
    input logic       wr_strobe,
    input logic       rd_strobe,
    input logic       irq_ack,
    input logic       ext_event,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [7:0] io_a_out,
    input logic [7:0] io_b_out
);
    logic unmapped_rd;
    assign unmapped_rd = (port_addr > 8'h80) && (port_addr != 8'hCF);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        ext_event |=> irq);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !ext_event) |=> !irq);

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!irq_ack && !ext_event) |=> $stable(irq));

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && unmapped_rd) |=> (rd_data == 8'h00));

    p_ioa_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && port_addr == 8'h80) |=> (io_a_out == $past(wr_data)));

    p_iob_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_strobe && port_addr == 8'hC0) |=> $stable(io_b_out));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !irq && io_a_out == 8'h00 && io_b_out == 8'h00));
endmodule

bind pio_fabric pio_fabric_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_addr (port_addr),
    .wr_data   (wr_data),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .irq_ack   (irq_ack),
    .ext_event (ext_event),
    .rd_data   (rd_data),
    .irq       (irq),
    .io_a_out  (io_a_out),
    .io_b_out  (io_b_out)
);

// File: tb/pio_fabric_bench.sv
module pio_fabric_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_strobe = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ext_event = 1'b0;
    logic [7:0] ext_in = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [7:0] io_a_out;
    logic [7:0] io_b_out;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    pio_fabric u_pio_fabric (
        .clk       (clk),
        .rst       (rst),
        .port_addr (port_addr),
        .wr_data   (wr_data),
        .wr_strobe (wr_strobe),
        .rd_strobe (rd_strobe),
        .irq_ack   (irq_ack),
        .ext_event (ext_event),
        .ext_in    (ext_in),
        .rd_data   (rd_data),
        .irq       (irq),
        .io_a_out  (io_a_out),
        .io_b_out  (io_b_out)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] table_ref(input int i);
        return 8'(((i * 37) + 5) % 256) ^ 8'hA5;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; wr_data = d; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        port_addr = a; rd_strobe = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // monitor: each sampled read strobe yields one result half a cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_strobe && !rst) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check(rd_data, 8'hxx, "scoreboard underflow");
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(rd_data, it.exp, it.tag);
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(rd_data, 8'h00, "R10 rd_data after reset");
        check({7'd0, irq}, 8'h00, "R10 irq after reset");
        check(io_a_out, 8'h00, "R10 io_a after reset");
        check(io_b_out, 8'h00, "R10 io_b after reset");
        rd(8'h10, 8'h00, "R10 ram cleared");

        // R1 RAM
        wr(8'h00, 8'h11);
        wr(8'h3F, 8'hEE);
        wr(8'h15, 8'h5A);
        rd(8'h00, 8'h11, "R1 ram low");
        rd(8'h3F, 8'hEE, "R1 ram high");
        rd(8'h15, 8'h5A, "R1 ram mid");

        // R2 hold after read
        repeat (3) @(negedge clk);
        check(rd_data, 8'h5A, "R2 rd_data holds");

        // R3 table and ignored writes
        for (int i = 0; i < 64; i += 9) rd(8'(8'h40 + i), table_ref(i), "R3 table");
        rd(8'h7F, table_ref(63), "R3 table top");
        wr(8'h45, 8'h00);
        rd(8'h45, table_ref(5), "R3 write ignored");
        rd(8'h05, 8'h00, "R3 ram untouched");

        // R4 bidirectional register
        wr(8'h80, 8'hC3);
        check(io_a_out, 8'hC3, "R4 io_a drives");
        rd(8'h80, 8'hC3, "R4 readback");

        // R5 write-only register
        wr(8'hC0, 8'h3C);
        check(io_b_out, 8'h3C, "R5 io_b drives");
        rd(8'hC0, 8'h00, "R5 read returns zero");
        check(io_a_out, 8'hC3, "R5 io_a unchanged");

        // R6 sampled input
        @(negedge clk); ext_in = 8'h9D;
        @(negedge clk);
        rd(8'hCF, 8'h9D, "R6 sampled input");
        wr(8'hCF, 8'h01);
        rd(8'hCF, 8'h9D, "R6 write ignored");
        @(negedge clk); ext_in = 8'h42;
        @(negedge clk);
        rd(8'hCF, 8'h42, "R6 new sample");

        // R7 unmapped
        rd(8'h81, 8'h00, "R7 unmapped 81");
        rd(8'hC5, 8'h00, "R7 unmapped C5");
        rd(8'hFF, 8'h00, "R7 unmapped FF");
        wr(8'hA0, 8'h77);
        wr(8'hD0, 8'h66);
        check(io_a_out, 8'hC3, "R7 io_a unchanged");
        check(io_b_out, 8'h3C, "R7 io_b unchanged");
        rd(8'h20, 8'h00, "R7 ram alias untouched");
        rd(8'h15, 8'h5A, "R7 ram intact");

        // R8 set, R9 clear and priority
        @(negedge clk); ext_event = 1'b1;
        @(negedge clk); ext_event = 1'b0;
        check({7'd0, irq}, 8'h01, "R8 event sets irq");
        repeat (2) @(negedge clk);
        check({7'd0, irq}, 8'h01, "R8 irq held");
        irq_ack = 1'b1; ext_event = 1'b1;
        @(negedge clk); irq_ack = 1'b0; ext_event = 1'b0;
        check({7'd0, irq}, 8'h01, "R9 set wins over ack");
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check({7'd0, irq}, 8'h00, "R9 ack clears");
        irq_ack = 1'b1; ext_event = 1'b1;
        @(negedge clk); irq_ack = 1'b0; ext_event = 1'b0;
        check({7'd0, irq}, 8'h01, "R9 set wins from idle");

        // R10 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({7'd0, irq}, 8'h00, "R10 irq cleared");
        check(io_a_out, 8'h00, "R10 io_a cleared");
        check(io_b_out, 8'h00, "R10 io_b cleared");
        check(rd_data, 8'h00, "R10 rd_data cleared");
        rd(8'h15, 8'h00, "R10 ram byte cleared");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) check(8'(sb_q.size()), 8'h00, "scoreboard drained");
        finish_run();
    end
endmodule